// File: doc/BRIEF.md
# Two-Wire Serial Memory Target (128 x 8)

This block is a 128-byte memory that answers as a target on a two-wire serial bus. It runs entirely on the system clock. SCL and SDA are oversampled: each line passes through a two-flop synchronizer, and its edges are found by comparing the current synchronized sample with the previous one. SDA is open-drain. The block observes the resolved bus level on `sda_in`. When it needs a low level it raises `sda_pull_low`, and board logic turns that into a pull-down.

A transaction begins with a START condition. The controller then sends a device byte, made of a 7-bit identity followed by a direction bit. A matching write carries one word-address byte and then any number of data bytes. Each data byte lands at the current pointer, and the pointer then advances with wrap. A read returns bytes from the current pointer for as long as the controller acknowledges them. A random read is done by sending a word address and then issuing a repeated START in the read direction.

All pins are plain bus lines. There is no stream handshake, because the byte flow is paced entirely by the controller's SCL. The memory clears to zero on reset.

Top module: `twowire_eeprom`

## Requirements
- R1: After reset, `sda_pull_low` is 0, the block waits for a START, and every memory byte reads as 0x00.
- R2: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. An SDA change during SCL high is never taken as a data bit, so a STOP in the middle of a byte discards that partial byte.
- R3: After a START, the first 8 bits, sent MSB first, are the device identity 1010000 followed by a direction bit (1 = read, 0 = write).
- R4: After each accepted byte (a matching device byte, a word address, or a write data byte), the target pulls SDA low for the 9th SCL pulse and releases it after that pulse.
- R5: The word address is 8 bits, MSB first. Bit 7 is ignored and bits 6:0 select the byte.
- R6: A STOP returns the target to idle with SDA released. SCL pulses that arrive before the next START get no acknowledge and have no effect.
- R7: A device byte whose identity is not 1010000 gets no acknowledge, and all traffic up to the next START or STOP leaves SDA untouched.
- R8: Each write data byte is stored at the current pointer, and the pointer then increments modulo 128.
- R9: In a read, the target drives each byte MSB first, changes SDA only after a falling SCL edge, and steps the pointer modulo 128. It releases SDA for the acknowledge slot and stops driving after the controller answers with a NACK (SDA high).
- R10: A repeated START restarts the device-byte phase and keeps the current pointer, so a read that follows a write of a word address starts at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Resolved bus data line level |
| sda_pull_low | output | 1 | 1 = pull SDA low (open-drain drive) |

## Verification
Directed transfers cover the corner cases:
- a wrong identity followed by more bytes, which separates address matching from simple acknowledging;
- clocking without a START after a STOP, which separates idle from active decode;
- a STOP in the middle of a byte, which separates bus conditions from data;
- writes and reads that cross address 127, which expose pointer wrap.

Word addresses with bit 7 set, read back through the same address with bit 7 clear, show that the top bit is ignored. Random bursts of random length, at random addresses, write data and then read it back through a repeated START. Each read is compared with a bench model, which tells correct storage and ordering apart from lost, shifted or misplaced bytes. A final NACK followed by a quiet window confirms that the target lets go of the bus.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = 4;
  localparam logic [CNT_W-1:0] CNT_ACK  = 4'd8;  // 8 bits done, ack slot next
  localparam logic [CNT_W-1:0] CNT_POST = 4'd9;  // 9th pulse seen

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START (power-down)
    ST_DEV,    // receiving device byte
    ST_WADDR,  // receiving word address
    ST_WDATA,  // receiving write data
    ST_RDATA,  // sending read data
    ST_SKIP    // not addressed / read ended, wait for START or STOP
  } twm_state_e;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] now,
  output logic [LINES-1:0] last
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign now[g]  = chain[STAGES-1];
    assign last[g] = prev;
  end
endmodule

// File: rtl/twm_store.sv
module twm_store #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];

  AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cells[$past(addr)] == $past(wdata)); // R8
endmodule

// File: rtl/twm_proto.sv
module twm_proto
  import twm_pkg::*;
#(
  parameter int         AW     = 7,
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl,
  input  logic                scl_q,
  input  logic                sda,
  input  logic                sda_q,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                pull
);
  twm_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, txsr, nxt;
  logic [AW-1:0]     ptr;
  logic              ack_go, rw;
  logic              rise, fall, start, stop, rx_state;
  logic [2:0]        bidx;

  assign rise     = scl & ~scl_q;
  assign fall     = ~scl & scl_q;
  assign start    = scl & scl_q & sda_q & ~sda;
  assign stop     = scl & scl_q & ~sda_q & sda;
  assign rx_state = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_WDATA);
  assign nxt      = {shreg[BYTE_W-2:0], sda};
  assign bidx     = 3'd7 - cnt[2:0];

  assign mem_addr  = ptr;
  assign mem_wdata = nxt;
  assign mem_we    = rise && (state == ST_WDATA) && (cnt == 4'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      txsr   <= '0;
      ptr    <= '0;
      pull   <= 1'b0;
      ack_go <= 1'b0;
      rw     <= 1'b0;
    end else if (stop) begin
      state <= ST_IDLE;
      pull  <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      state <= ST_DEV;
      pull  <= 1'b0;
      cnt   <= '0;
    end else if (rx_state) begin
      if (rise) begin
        if (cnt < CNT_ACK) begin
          shreg <= nxt;
          cnt   <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            case (state)
              ST_DEV: begin
                ack_go <= (nxt[7:1] == DEV_ID);
                rw     <= nxt[0];
              end
              ST_WADDR: begin
                ptr    <= nxt[AW-1:0];
                ack_go <= 1'b1;
              end
              default: begin
                ptr    <= ptr + 1'b1;
                ack_go <= 1'b1;
              end
            endcase
          end
        end else if (cnt == CNT_ACK) begin
          cnt <= CNT_POST;
        end
      end else if (fall) begin
        if (cnt == CNT_ACK) begin
          pull <= ack_go;
          if (!ack_go) state <= ST_SKIP;
        end else if (cnt == CNT_POST) begin
          pull <= 1'b0;
          cnt  <= '0;
          case (state)
            ST_DEV: begin
              if (rw) begin
                state <= ST_RDATA;
                txsr  <= mem_rdata;
                pull  <= ~mem_rdata[7];
                ptr   <= ptr + 1'b1;
              end else begin
                state <= ST_WADDR;
              end
            end
            ST_WADDR: state <= ST_WDATA;
            default:  ;
          endcase
        end
      end
    end else if (state == ST_RDATA) begin
      if (rise) begin
        if (cnt == CNT_ACK) begin
          cnt <= CNT_POST;
          if (sda) state <= ST_SKIP;
        end else begin
          cnt <= cnt + 4'd1;
        end
      end else if (fall) begin
        if (cnt == CNT_ACK) begin
          pull <= 1'b0;
        end else if (cnt == CNT_POST) begin
          cnt  <= '0;
          txsr <= mem_rdata;
          pull <= ~mem_rdata[7];
          ptr  <= ptr + 1'b1;
        end else if (cnt != '0) begin
          pull <= ~txsr[bidx];
        end
      end
    end
  end

  AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state && pull) |-> (cnt >= CNT_ACK)); // R4
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> !pull); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state == ST_IDLE) && !pull); // R6
  AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ST_DEV) && (cnt == '0)); // R2
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull) |-> $past(fall || start || stop)); // R9
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ptr == $past(ptr) + 1'b1); // R8
endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
  import twm_pkg::*;
#(
  parameter int         AW          = 7,
  parameter logic [6:0] DEV_ID      = 7'b1010000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull_low
);
  logic [1:0]        ln_now, ln_last;
  logic              we;
  logic [AW-1:0]     addr;
  logic [BYTE_W-1:0] wdata, rdata;

  twm_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({sda_in, scl_in}),
    .now(ln_now), .last(ln_last)
  );

  twm_proto #(.AW(AW), .DEV_ID(DEV_ID)) u_proto (
    .clk(clk), .rst_n(rst_n),
    .scl(ln_now[0]), .scl_q(ln_last[0]),
    .sda(ln_now[1]), .sda_q(ln_last[1]),
    .mem_we(we), .mem_addr(addr), .mem_wdata(wdata), .mem_rdata(rdata),
    .pull(sda_pull_low)
  );

  twm_store #(.AW(AW), .DW(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );
endmodule

// File: tb/twowire_eeprom_test.sv
module twowire_eeprom_test;
  localparam int Q = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_scl = 1'b1, ctl_sda = 1'b1;
  logic sda_pull_low;
  wire  bus_sda = ctl_sda & ~sda_pull_low;

  int checks = 0, failures = 0;
  logic saw_pull = 1'b0;
  logic [7:0] mdl [128];
  logic [7:0] wbuf [8];

  always #5 clk = ~clk;

  twowire_eeprom uut (.clk(clk), .rst_n(rst_n), .scl_in(ctl_scl),
                      .sda_in(bus_sda), .sda_pull_low(sda_pull_low));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] slot(input logic [7:0] wa, input int k);
    return 7'(wa[6:0] + k);
  endfunction

  task automatic tick(); @(negedge clk); if (sda_pull_low) saw_pull = 1'b1; endtask
  task automatic waitq(); repeat (Q) tick(); endtask
  task automatic bus_start();
    ctl_sda = 1; waitq(); ctl_scl = 1; waitq(); ctl_sda = 0; waitq(); ctl_scl = 0; waitq();
  endtask
  task automatic bus_stop();
    ctl_sda = 0; waitq(); ctl_scl = 1; waitq(); ctl_sda = 1; waitq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      ctl_sda = b[i]; waitq(); ctl_scl = 1; waitq(); waitq(); ctl_scl = 0; waitq();
    end
    ctl_sda = 1; waitq(); ctl_scl = 1; waitq(); acked = ~bus_sda; waitq(); ctl_scl = 0; waitq();
  endtask
  task automatic recv_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      ctl_sda = 1; waitq(); ctl_scl = 1; waitq(); b[i] = bus_sda; waitq(); ctl_scl = 0; waitq();
    end
    ctl_sda = nack; waitq(); ctl_scl = 1; waitq(); waitq(); ctl_scl = 0; waitq();
  endtask

  task automatic write_burst(input logic [7:0] wa, input int n);
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk("R3 write device ack", a, 1);
    send_byte(wa, a);    chk("R4 word address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); chk("R4 data ack", a, 1);
      mdl[slot(wa, k)] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic read_burst(input logic [7:0] wa, input int n, input string tag);
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hA0, a); chk("R3 device ack", a, 1);
    send_byte(wa, a);    chk("R5 word address ack", a, 1);
    bus_start();
    send_byte(8'hA1, a); chk("R10 read device ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k == n - 1);
      chk(tag, d, mdl[slot(wa, k)]);
    end
    saw_pull = 0; waitq(); waitq();
    chk("R9 released after NACK", saw_pull, 0);
    bus_stop();
  endtask

  task automatic run_all();
    logic a; logic [7:0] d;
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    void'($urandom(32'd2024));
    repeat (4) tick();
    rst_n = 1;
    repeat (4) tick();
    chk("R1 released after reset", sda_pull_low, 0);
    read_burst(8'h40, 2, "R1 cleared memory");

    // wrong identity: no ack, rest ignored
    bus_start(); saw_pull = 0;
    send_byte(8'hA2, a); chk("R7 no ack for wrong id", a, 0);
    send_byte(8'h10, a); send_byte(8'h55, a);
    chk("R7 bus untouched", saw_pull, 0);
    bus_stop();
    bus_start(); send_byte(8'hB1, a); chk("R7 no ack for wrong read id", a, 0); bus_stop();

    // clocking after STOP without START
    saw_pull = 0;
    send_byte(8'hA0, a); send_byte(8'h10, a);
    chk("R6 idle ignores clocks", saw_pull, 0);

    // wrap across 127 with top address bit set
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    write_burst(8'hFE, 4);
    read_burst(8'h7F, 3, "R8 wrap write/read");
    read_burst(8'h80, 2, "R5 top bit ignored");

    // STOP in the middle of a data byte
    wbuf[0] = 8'h3C; write_burst(8'h10, 1);
    bus_start(); send_byte(8'hA0, a); send_byte(8'h10, a);
    for (int i = 0; i < 4; i++) begin
      ctl_sda = 1; waitq(); ctl_scl = 1; waitq(); waitq(); ctl_scl = 0; waitq();
    end
    bus_stop();
    read_burst(8'h90, 1, "R2 partial byte dropped");

    // current-address read keeps the pointer
    read_burst(8'h20, 1, "R9 read");
    bus_start(); send_byte(8'hA1, a); chk("R10 current read ack", a, 1);
    recv_byte(d, 1'b1); chk("R10 pointer kept", d, mdl[8'h21]);
    bus_stop();

    // random bursts
    for (int t = 0; t < 10; t++) begin
      logic [7:0] wa; int n;
      wa = 8'($urandom);
      n  = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      write_burst(wa, n);
      read_burst(wa ^ 8'h80, n, "R9 random readback");
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule